// File: doc/BRIEF.md
# ATA Single-Sector Transfer Sequencer

This block runs one complete single-sector PIO command against an ATA device on a parallel register bus. A request carries a direction (read or write), a unit select (master or slave), a cylinder high byte, a cylinder low byte and a sector number. The block first checks a sticky not-ready flag. If the flag is set, it soft-resets the device through the device control register. It then waits for the drive to become ready, programs the task file and issues the command. Next it waits for a data request and moves 256 sixteen-bit words between the device data register and a local 256-word synchronous buffer port. It finishes by checking the error bit again.

Every register access goes through a small cycle engine. The engine drives the register select one cycle ahead of the strobe, holds the strobe for a programmable number of cycles, and keeps the select for one more cycle after the strobe falls. Poll intervals, the reset pulse length and both poll limits are parameters in clock cycles. A done pulse ends every request. It carries a result code, the last status byte read and the error byte, which is latched when the device reports an error.

Top module: `ata_sector_seq`

## Requirements
- R1: After rst_n the block is idle (busy=0, done=0, no strobe, buf_we=0). The not-ready flag is set, so the first accepted command runs the reset sequence.
- R2: The reset sequence runs only while the not-ready flag is set. It writes 0x0E to the device control register (select {cs1,cs0,a}=5'b10110), waits at least RST_CYC cycles, writes 0x02 there, then clears the flag.
- R3: The task file is written in this order: sector count (5'b01010) = 0x01; drive/head (5'b01110) = 0xE0 for unit 0 or 0xF0 for unit 1; cylinder high (5'b01101); cylinder low (5'b01100); sector number (5'b01011).
- R4: After the task file, the command register (5'b01111) is written with 0x20 for a read (req_wr=0) or 0x30 for a write (req_wr=1).
- R5: A ready poll reads status (5'b01111) every POLL_CYC cycles until bit7=0 and bit6=1. After RDY_LIMIT unsuccessful reads it ends with result 2.
- R6: After the command is accepted without error, a data-request poll waits for bit7=0 and bit3=1. After DRQ_LIMIT unsuccessful reads it ends with result 3.
- R7: An error check reads status. If bit0 is set, it reads the error register (5'b01001), latches it on err_byte and ends with result 1. This check runs after the command and again after the data phase.
- R8: The data phase performs 256 data-register (5'b01000) cycles. A read stores the i-th device word at buffer address i. A write sends buffer word i as the i-th device word.
- R9: Any result from 1 to 3 sets the not-ready flag, so the next command resets first. A successful command (result 0) leaves the flag clear and the next command issues no reset.
- R10: A unit select of 2 or 3 ends with result 4 within two cycles of the request. No bus cycle is made and the not-ready flag is left unchanged.
- R11: busy rises the cycle after a request is accepted and stays high until a one-cycle done pulse. result, stat_byte and err_byte are valid with done. stat_byte and err_byte are cleared at the start of each command.
- R12: Every register access drives a non-zero select one cycle before its strobe and keeps it stable while the strobe is high. dev_rd and dev_wr are never high together, and dev_oe is low during reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | One-cycle command request, accepted while idle |
| req_wr | input | 1 | 1 = sector write, 0 = sector read |
| req_unit | input | 2 | Unit select; 0 master, 1 slave, others illegal |
| req_cylhi | input | 8 | Cylinder high byte |
| req_cyllo | input | 8 | Cylinder low byte |
| req_sector | input | 8 | Sector number |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 3 | 0 ok, 1 command error, 2 ready timeout, 3 data-request timeout, 4 bad unit |
| stat_byte | output | 8 | Last status byte read |
| err_byte | output | 8 | Error register byte latched on error |
| buf_addr | output | 8 | Local buffer word address |
| buf_we | output | 1 | Local buffer write enable |
| buf_wdata | output | 16 | Local buffer write data |
| buf_rdata | input | 16 | Local buffer read data, one cycle after address |
| dev_cs0 | output | 1 | Command-block chip select (active high) |
| dev_cs1 | output | 1 | Control-block chip select (active high) |
| dev_a | output | 3 | Device register address |
| dev_rd | output | 1 | Read strobe (active high) |
| dev_wr | output | 1 | Write strobe (active high) |
| dev_oe | output | 1 | Host drives dev_dout onto the device data bus |
| dev_dout | output | 16 | Write data to device |
| dev_din | input | 16 | Read data from device |

## Verification
The bench sweeps both directions, both units and eight address patterns against a device model. It checks the full register-write log and all 256 words of each transfer. A block that wrote the task file in the wrong order, mixed up the head value or miscounted words would fail the log or buffer comparison. The failure paths are each driven on purpose: a stuck busy bit, a missing data request, and an error raised after the command or after the data phase. The bench counts status reads against the poll limits and checks that the next command begins with a reset. A design with an off-by-one poll limit or a flag that does not stick would be caught there. Illegal units are tried both while the flag is set and while it is clear, so a design that touched the bus or the flag on rejection would show it in the next command's log.

// File: rtl/ata_seq_pkg.sv
// Shared constants for the single-sector sequencer.
// Register select is {cs1, cs0, a[2:0]}; chip selects are active high.
package ata_seq_pkg;
    typedef enum logic [2:0] {
        RC_OK      = 3'd0,
        RC_CMDERR  = 3'd1,
        RC_RDYTO   = 3'd2,
        RC_BUFTO   = 3'd3,
        RC_BADUNIT = 3'd4
    } rc_t;

    localparam logic [4:0] SEL_DATA   = 5'b01000;
    localparam logic [4:0] SEL_ERR    = 5'b01001;
    localparam logic [4:0] SEL_FEAT   = 5'b01001;
    localparam logic [4:0] SEL_SCNT   = 5'b01010;
    localparam logic [4:0] SEL_SECT   = 5'b01011;
    localparam logic [4:0] SEL_CYLLO  = 5'b01100;
    localparam logic [4:0] SEL_CYLHI  = 5'b01101;
    localparam logic [4:0] SEL_HEAD   = 5'b01110;
    localparam logic [4:0] SEL_CMD    = 5'b01111;
    localparam logic [4:0] SEL_STAT   = 5'b01111;
    localparam logic [4:0] SEL_DEVCTL = 5'b10110;

    localparam logic [7:0] OP_READ    = 8'h20;
    localparam logic [7:0] OP_WRITE   = 8'h30;
    localparam logic [7:0] OP_SETFEAT = 8'hEF;
    localparam logic [7:0] CTL_RST_ON  = 8'h0E;
    localparam logic [7:0] CTL_RST_OFF = 8'h02;
endpackage

// File: rtl/ata_reg_cycle.sv
// Register cycle engine: performs one device register read or write.
// Assumes req is a one-cycle pulse, only honoured while the engine is idle.
// Timing: one setup cycle with select driven, STB_CYC strobe cycles,
// one hold cycle (ack high) with select kept, then select released.
module ata_reg_cycle #(
    parameter int STB_CYC = 3,
    parameter int DW      = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          req_wr,
    input  logic [4:0]    req_sel,
    input  logic [DW-1:0] req_wdata,
    output logic          ack,
    output logic [DW-1:0] rdata,
    output logic          dev_cs0,
    output logic          dev_cs1,
    output logic [2:0]    dev_a,
    output logic          dev_rd,
    output logic          dev_wr,
    output logic          dev_oe,
    output logic [DW-1:0] dev_dout,
    input  logic [DW-1:0] dev_din
);
    localparam int SW = $clog2(STB_CYC + 1);

    typedef enum logic [1:0] {P_IDLE, P_SETUP, P_STB, P_HOLD} phase_t;

    phase_t         phase;
    logic [SW-1:0]  cnt;
    logic           is_wr;
    logic [4:0]     sel;

    // Phase sequencing, select/data capture and read sampling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= P_IDLE;
            cnt      <= '0;
            is_wr    <= 1'b0;
            sel      <= '0;
            dev_dout <= '0;
            rdata    <= '0;
        end else begin
            case (phase)
                P_IDLE: if (req) begin
                    sel      <= req_sel;
                    is_wr    <= req_wr;
                    dev_dout <= req_wdata;
                    phase    <= P_SETUP;
                end
                P_SETUP: begin
                    cnt   <= '0;
                    phase <= P_STB;
                end
                P_STB: begin
                    if (cnt == SW'(STB_CYC - 1)) begin
                        phase <= P_HOLD;
                        if (!is_wr) rdata <= dev_din;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    sel   <= '0;
                    phase <= P_IDLE;
                end
            endcase
        end
    end

    // Bus pins decoded from the registered phase.
    always_comb begin
        dev_cs1 = sel[4];
        dev_cs0 = sel[3];
        dev_a   = sel[2:0];
        dev_rd  = (phase == P_STB) && !is_wr;
        dev_wr  = (phase == P_STB) && is_wr;
        dev_oe  = (phase != P_IDLE) && is_wr;
        ack     = (phase == P_HOLD);
    end
endmodule

// File: rtl/ata_wait_timer.sv
// Down-counting delay timer. A load pulse with value N (N >= 1) makes
// done high exactly N cycles after the load cycle; done is one cycle wide.
module ata_wait_timer #(
    parameter int CW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] val,
    output logic          done
);
    logic [CW-1:0] cnt;

    // Count down towards zero after a load.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign done = (cnt == CW'(1));
endmodule

// File: rtl/ata_sector_seq.sv
// Single-sector PIO command sequencer.
// Runs reset-on-demand, ready/data-request polling with limits, task-file
// programming, command issue, a WORDS-word data phase and error checks.
// Assumes req is a one-cycle pulse; requests while busy are ignored.
// The local buffer is synchronous: buf_rdata follows buf_addr by one cycle.
module ata_sector_seq
    import ata_seq_pkg::*;
#(
    parameter int WORDS     = 256,
    parameter int STB_CYC   = 3,
    parameter int RST_CYC   = 10_000_000,
    parameter int POLL_CYC  = 12_500,
    parameter int RDY_LIMIT = 65536,
    parameter int DRQ_LIMIT = 65536,
    parameter bit EIGHT_BIT = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req,
    input  logic        req_wr,
    input  logic [1:0]  req_unit,
    input  logic [7:0]  req_cylhi,
    input  logic [7:0]  req_cyllo,
    input  logic [7:0]  req_sector,
    output logic        busy,
    output logic        done,
    output logic [2:0]  result,
    output logic [7:0]  stat_byte,
    output logic [7:0]  err_byte,
    output logic [$clog2(WORDS)-1:0] buf_addr,
    output logic        buf_we,
    output logic [15:0] buf_wdata,
    input  logic [15:0] buf_rdata,
    output logic        dev_cs0,
    output logic        dev_cs1,
    output logic [2:0]  dev_a,
    output logic        dev_rd,
    output logic        dev_wr,
    output logic        dev_oe,
    output logic [15:0] dev_dout,
    input  logic [15:0] dev_din
);
    localparam int AW   = $clog2(WORDS);
    localparam int TMAX = (RST_CYC > POLL_CYC) ? RST_CYC : POLL_CYC;
    localparam int CW   = $clog2(TMAX + 1);
    localparam int PMAX = (RDY_LIMIT > DRQ_LIMIT) ? RDY_LIMIT : DRQ_LIMIT;
    localparam int PW   = $clog2(PMAX + 1);

    typedef enum logic [4:0] {
        S_IDLE, S_BUS, S_TMR, S_RST_WAIT, S_RST_REL, S_RST_END,
        S_FEAT, S_FEAT_CMD, S_PRE, S_RDY, S_RDY_RD, S_RDY_CHK,
        S_TF, S_POST_CMD, S_ERR, S_ERR_CHK, S_ERR_LATCH,
        S_DRQ, S_DRQ_RD, S_DRQ_CHK, S_XFER, S_XFER_WR, S_XFER_NX,
        S_POST_DATA, S_DONE
    } state_t;

    typedef enum logic [1:0] {C_FEAT, C_PRE, C_CMD, C_DATA} ctx_t;

    state_t         state, ret;
    ctx_t           ctx;
    logic           nrdy;
    logic           wr_q, unit_q;
    logic [7:0]     cylhi_q, cyllo_q, sect_q;
    logic [2:0]     step;
    logic [PW-1:0]  pcnt;
    logic [AW-1:0]  widx;
    rc_t            rc;

    logic           cyc_req, cyc_wr, cyc_ack;
    logic [4:0]     cyc_sel;
    logic [15:0]    cyc_wdata, cyc_rdata;
    logic           tmr_load, tmr_done;
    logic [CW-1:0]  tmr_val;
    logic [4:0]     tf_sel;
    logic [7:0]     tf_data;

    ata_reg_cycle #(.STB_CYC(STB_CYC), .DW(16)) u_cyc (
        .clk(clk), .rst_n(rst_n),
        .req(cyc_req), .req_wr(cyc_wr), .req_sel(cyc_sel), .req_wdata(cyc_wdata),
        .ack(cyc_ack), .rdata(cyc_rdata),
        .dev_cs0(dev_cs0), .dev_cs1(dev_cs1), .dev_a(dev_a),
        .dev_rd(dev_rd), .dev_wr(dev_wr), .dev_oe(dev_oe),
        .dev_dout(dev_dout), .dev_din(dev_din)
    );

    ata_wait_timer #(.CW(CW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .val(tmr_val), .done(tmr_done)
    );

    // Task-file register and value for the current programming step.
    always_comb begin
        case (step)
            3'd0:    begin tf_sel = SEL_SCNT;  tf_data = 8'h01; end
            3'd1:    begin tf_sel = SEL_HEAD;  tf_data = {3'b111, unit_q, 4'b0000}; end
            3'd2:    begin tf_sel = SEL_CYLHI; tf_data = cylhi_q; end
            3'd3:    begin tf_sel = SEL_CYLLO; tf_data = cyllo_q; end
            3'd4:    begin tf_sel = SEL_SECT;  tf_data = sect_q; end
            default: begin tf_sel = SEL_CMD;   tf_data = wr_q ? OP_WRITE : OP_READ; end
        endcase
    end

    // Main command sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            ret       <= S_IDLE;
            ctx       <= C_PRE;
            nrdy      <= 1'b1;
            wr_q      <= 1'b0;
            unit_q    <= 1'b0;
            cylhi_q   <= '0;
            cyllo_q   <= '0;
            sect_q    <= '0;
            step      <= '0;
            pcnt      <= '0;
            widx      <= '0;
            rc        <= RC_OK;
            stat_byte <= '0;
            err_byte  <= '0;
            cyc_req   <= 1'b0;
            cyc_wr    <= 1'b0;
            cyc_sel   <= '0;
            cyc_wdata <= '0;
            tmr_load  <= 1'b0;
            tmr_val   <= '0;
        end else begin
            cyc_req  <= 1'b0;
            tmr_load <= 1'b0;
            case (state)
                S_IDLE: if (req) begin
                    stat_byte <= '0;
                    err_byte  <= '0;
                    rc        <= RC_OK;
                    wr_q      <= req_wr;
                    unit_q    <= req_unit[0];
                    cylhi_q   <= req_cylhi;
                    cyllo_q   <= req_cyllo;
                    sect_q    <= req_sector;
                    if (req_unit > 2'd1) begin
                        rc    <= RC_BADUNIT;
                        state <= S_DONE;
                    end else if (nrdy) begin
                        cyc_req <= 1'b1; cyc_wr <= 1'b1;
                        cyc_sel <= SEL_DEVCTL; cyc_wdata <= {8'h00, CTL_RST_ON};
                        ret <= S_RST_WAIT; state <= S_BUS;
                    end else begin
                        state <= S_PRE;
                    end
                end
                S_BUS: if (cyc_ack) state <= ret;
                S_TMR: if (tmr_done) state <= ret;
                S_RST_WAIT: begin
                    tmr_load <= 1'b1; tmr_val <= CW'(RST_CYC);
                    ret <= S_RST_REL; state <= S_TMR;
                end
                S_RST_REL: begin
                    cyc_req <= 1'b1; cyc_wr <= 1'b1;
                    cyc_sel <= SEL_DEVCTL; cyc_wdata <= {8'h00, CTL_RST_OFF};
                    ret <= S_RST_END; state <= S_BUS;
                end
                S_RST_END: begin
                    nrdy <= 1'b0;
                    if (EIGHT_BIT) begin
                        ctx <= C_FEAT; pcnt <= '0; state <= S_RDY;
                    end else begin
                        state <= S_PRE;
                    end
                end
                S_FEAT: begin
                    cyc_req <= 1'b1; cyc_wr <= 1'b1;
                    cyc_sel <= SEL_FEAT; cyc_wdata <= 16'h0001;
                    ret <= S_FEAT_CMD; state <= S_BUS;
                end
                S_FEAT_CMD: begin
                    cyc_req <= 1'b1; cyc_wr <= 1'b1;
                    cyc_sel <= SEL_CMD; cyc_wdata <= {8'h00, OP_SETFEAT};
                    ret <= S_PRE; state <= S_BUS;
                end
                S_PRE: begin
                    ctx <= C_PRE; pcnt <= '0; state <= S_RDY;
                end
                S_RDY: begin
                    tmr_load <= 1'b1; tmr_val <= CW'(POLL_CYC);
                    ret <= S_RDY_RD; state <= S_TMR;
                end
                S_RDY_RD: begin
                    if (pcnt == PW'(RDY_LIMIT)) begin
                        rc <= RC_RDYTO; nrdy <= 1'b1; state <= S_DONE;
                    end else begin
                        pcnt    <= pcnt + 1'b1;
                        cyc_req <= 1'b1; cyc_wr <= 1'b0; cyc_sel <= SEL_STAT;
                        ret <= S_RDY_CHK; state <= S_BUS;
                    end
                end
                S_RDY_CHK: begin
                    stat_byte <= cyc_rdata[7:0];
                    if (cyc_rdata[7:6] == 2'b01) begin
                        case (ctx)
                            C_FEAT:  state <= S_FEAT;
                            C_PRE:   begin step <= '0; state <= S_TF; end
                            default: state <= S_ERR;
                        endcase
                    end else begin
                        state <= S_RDY;
                    end
                end
                S_TF: begin
                    cyc_req <= 1'b1; cyc_wr <= 1'b1;
                    cyc_sel <= tf_sel; cyc_wdata <= {8'h00, tf_data};
                    step    <= step + 1'b1;
                    ret     <= (step == 3'd5) ? S_POST_CMD : S_TF;
                    state   <= S_BUS;
                end
                S_POST_CMD: begin
                    ctx <= C_CMD; pcnt <= '0; state <= S_RDY;
                end
                S_ERR: begin
                    cyc_req <= 1'b1; cyc_wr <= 1'b0; cyc_sel <= SEL_STAT;
                    ret <= S_ERR_CHK; state <= S_BUS;
                end
                S_ERR_CHK: begin
                    stat_byte <= cyc_rdata[7:0];
                    if (cyc_rdata[0]) begin
                        cyc_req <= 1'b1; cyc_wr <= 1'b0; cyc_sel <= SEL_ERR;
                        ret <= S_ERR_LATCH; state <= S_BUS;
                    end else if (ctx == C_CMD) begin
                        pcnt <= '0; state <= S_DRQ;
                    end else begin
                        rc <= RC_OK; state <= S_DONE;
                    end
                end
                S_ERR_LATCH: begin
                    err_byte <= cyc_rdata[7:0];
                    rc <= RC_CMDERR; nrdy <= 1'b1; state <= S_DONE;
                end
                S_DRQ: begin
                    tmr_load <= 1'b1; tmr_val <= CW'(POLL_CYC);
                    ret <= S_DRQ_RD; state <= S_TMR;
                end
                S_DRQ_RD: begin
                    if (pcnt == PW'(DRQ_LIMIT)) begin
                        rc <= RC_BUFTO; nrdy <= 1'b1; state <= S_DONE;
                    end else begin
                        pcnt    <= pcnt + 1'b1;
                        cyc_req <= 1'b1; cyc_wr <= 1'b0; cyc_sel <= SEL_STAT;
                        ret <= S_DRQ_CHK; state <= S_BUS;
                    end
                end
                S_DRQ_CHK: begin
                    stat_byte <= cyc_rdata[7:0];
                    if (!cyc_rdata[7] && cyc_rdata[3]) begin
                        widx <= '0; state <= S_XFER;
                    end else begin
                        state <= S_DRQ;
                    end
                end
                S_XFER: begin
                    if (wr_q) begin
                        state <= S_XFER_WR;
                    end else begin
                        cyc_req <= 1'b1; cyc_wr <= 1'b0; cyc_sel <= SEL_DATA;
                        ret <= S_XFER_NX; state <= S_BUS;
                    end
                end
                S_XFER_WR: begin
                    cyc_req <= 1'b1; cyc_wr <= 1'b1;
                    cyc_sel <= SEL_DATA; cyc_wdata <= buf_rdata;
                    ret <= S_XFER_NX; state <= S_BUS;
                end
                S_XFER_NX: begin
                    widx  <= widx + 1'b1;
                    state <= (widx == AW'(WORDS - 1)) ? S_POST_DATA : S_XFER;
                end
                S_POST_DATA: begin
                    ctx <= C_DATA; pcnt <= '0; state <= S_RDY;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Handshake and local buffer port.
    always_comb begin
        busy      = (state != S_IDLE);
        done      = (state == S_DONE);
        result    = rc;
        buf_addr  = widx;
        buf_we    = (state == S_XFER_NX) && !wr_q;
        buf_wdata = cyc_rdata;
    end
endmodule

// File: rtl/ata_sector_seq_chk.sv
// Protocol checker for ata_sector_seq, attached by bind below.
module ata_sector_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req,
    input logic       busy,
    input logic       done,
    input logic [2:0] result,
    input logic       buf_we,
    input logic       dev_cs0,
    input logic       dev_cs1,
    input logic [2:0] dev_a,
    input logic       dev_rd,
    input logic       dev_wr,
    input logic       dev_oe
);
    logic [4:0] sel;
    assign sel = {dev_cs1, dev_cs0, dev_a};

    a_r12_rd_wr_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(dev_rd && dev_wr));
    a_r12_oe_off_in_read: assert property (@(posedge clk) disable iff (!rst_n)
        dev_rd |-> !dev_oe);
    a_r12_setup_before_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(dev_rd) || $rose(dev_wr)) |-> (sel != 5'd0 && $stable(sel)));
    a_r12_sel_stable: assert property (@(posedge clk) disable iff (!rst_n)
        ((dev_rd || dev_wr) && ($past(dev_rd) || $past(dev_wr))) |-> $stable(sel));
    a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r11_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);
    a_r11_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!dev_rd && !dev_wr && !buf_we));
    a_r10_badunit_fast: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result == 3'd4) |-> $past(req));
endmodule

bind ata_sector_seq ata_sector_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req(req), .busy(busy), .done(done),
    .result(result), .buf_we(buf_we), .dev_cs0(dev_cs0), .dev_cs1(dev_cs1),
    .dev_a(dev_a), .dev_rd(dev_rd), .dev_wr(dev_wr), .dev_oe(dev_oe)
);

// File: tb/ata_sector_seq_bench.sv
module ata_sector_seq_bench;
    localparam int CLK_PER   = 10;
    localparam int STB       = 2;
    localparam int RSTC      = 12;
    localparam int POLLC     = 3;
    localparam int RDYL      = 6;
    localparam int DRQL      = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0, req_wr = 1'b0;
    logic [1:0] req_unit = '0;
    logic [7:0] req_cylhi = '0, req_cyllo = '0, req_sector = '0;
    logic busy, done;
    logic [2:0] result;
    logic [7:0] stat_byte, err_byte;
    logic [7:0] buf_addr;
    logic buf_we;
    logic [15:0] buf_wdata, buf_rdata;
    logic dev_cs0, dev_cs1, dev_rd, dev_wr, dev_oe;
    logic [2:0] dev_a;
    logic [15:0] dev_dout, dev_din;

    always #(CLK_PER/2) clk = ~clk;

    ata_sector_seq #(.WORDS(256), .STB_CYC(STB), .RST_CYC(RSTC), .POLL_CYC(POLLC),
                     .RDY_LIMIT(RDYL), .DRQ_LIMIT(DRQL), .EIGHT_BIT(1'b0)) u_ata_sector_seq (
        .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr), .req_unit(req_unit),
        .req_cylhi(req_cylhi), .req_cyllo(req_cyllo), .req_sector(req_sector),
        .busy(busy), .done(done), .result(result), .stat_byte(stat_byte), .err_byte(err_byte),
        .buf_addr(buf_addr), .buf_we(buf_we), .buf_wdata(buf_wdata), .buf_rdata(buf_rdata),
        .dev_cs0(dev_cs0), .dev_cs1(dev_cs1), .dev_a(dev_a), .dev_rd(dev_rd), .dev_wr(dev_wr),
        .dev_oe(dev_oe), .dev_dout(dev_dout), .dev_din(dev_din)
    );

    int total = 0, bad = 0;

    function automatic logic [15:0] dpat(input int seed, input int i);
        return 16'(seed * 16'h01F3 + i * 16'h0107) ^ 16'(i << 9);
    endfunction
    function automatic logic [15:0] bpat(input int seed, input int i);
        return 16'(seed * 16'h2B05 + i * 16'h0311) ^ 16'(i << 4);
    endfunction

    // ---------------- local buffer (256 x 16, synchronous) ----------------
    logic [15:0] bmem [0:255];
    logic fill = 1'b0;
    int fseed = 0;
    always @(posedge clk) begin
        if (fill) begin
            for (int i = 0; i < 256; i++) bmem[i] <= bpat(fseed, i);
        end else if (buf_we) begin
            bmem[buf_addr] <= buf_wdata;
        end
        buf_rdata <= bmem[buf_addr];
    end

    // ---------------- device model ----------------
    logic k_bsy = 0, k_nodrq = 0, k_errcmd = 0, k_errdata = 0;
    logic clr = 1'b0;
    int dseed = 0;
    logic [4:0] lsel [0:15];
    logic [7:0] ldat [0:15];
    int nlog, nstat, nerr, nrd, nwr, ph, cyc, ctl_t0, ctl_t1, nctl;
    logic [15:0] wmem [0:255];
    logic rd_p = 0, wr_p = 0;
    logic [4:0] dsel;
    logic [7:0] dstat;
    assign dsel = {dev_cs1, dev_cs0, dev_a};

    always_comb begin
        if (k_bsy)        dstat = 8'h80;
        else if (ph == 1) dstat = k_nodrq ? 8'h50 : (8'h58 | {7'd0, k_errcmd});
        else if (ph == 2) dstat = 8'h50 | {7'd0, k_errdata};
        else              dstat = 8'h50;
    end
    assign dev_din = (dsel == 5'b01111) ? {8'h00, dstat} :
                     (dsel == 5'b01001) ? 16'h0004 :
                     (dsel == 5'b01000) ? dpat(dseed, nrd) : 16'h0000;

    initial begin nlog = 0; nstat = 0; nerr = 0; nrd = 0; nwr = 0; ph = 0; cyc = 0;
        ctl_t0 = 0; ctl_t1 = 0; nctl = 0; end

    always @(posedge clk) begin
        cyc  <= cyc + 1;
        rd_p <= dev_rd;
        wr_p <= dev_wr;
        if (clr) begin
            nlog <= 0; nstat <= 0; nerr <= 0; nrd <= 0; nwr <= 0; ph <= 0; nctl <= 0;
        end else begin
            if (rd_p && !dev_rd) begin
                if (dsel == 5'b01111) nstat <= nstat + 1;
                if (dsel == 5'b01001) nerr <= nerr + 1;
                if (dsel == 5'b01000) begin
                    nrd <= nrd + 1;
                    if (nrd == 255) ph <= 2;
                end
            end
            if (wr_p && !dev_wr) begin
                if (dsel == 5'b01000) begin
                    wmem[nwr[7:0]] <= dev_dout;
                    nwr <= nwr + 1;
                    if (nwr == 255) ph <= 2;
                end else begin
                    if (nlog < 16) begin
                        lsel[nlog] <= dsel;
                        ldat[nlog] <= dev_dout[7:0];
                    end
                    nlog <= nlog + 1;
                    if (dsel == 5'b01111) ph <= 1;
                    if (dsel == 5'b10110) begin
                        if (nctl == 0) ctl_t0 <= cyc; else ctl_t1 <= cyc;
                        nctl <= nctl + 1;
                    end
                end
            end
        end
    end

    // ---------------- checking helpers ----------------
    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    int rc_c, st_c, er_c, lat_c;
    logic exp_nrdy = 1'b1;

    task automatic run(input bit wr, input [1:0] unit, input [7:0] ch, input [7:0] cl,
                       input [7:0] sc, input int seed);
        if (wr) begin
            @(negedge clk); fseed = seed; fill = 1'b1;
            @(negedge clk); fill = 1'b0;
        end
        @(negedge clk);
        dseed = seed; clr = 1'b1; req = 1'b1; req_wr = wr; req_unit = unit;
        req_cylhi = ch; req_cyllo = cl; req_sector = sc;
        @(negedge clk);
        clr = 1'b0; req = 1'b0;
        chk("R11 busy after accept", busy, 1);
        lat_c = 1;
        while (!done) begin
            @(negedge clk);
            lat_c++;
            if (lat_c > 20000) begin
                chk("R11 watchdog expired", 0, 1);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
        rc_c = result; st_c = stat_byte; er_c = err_byte;
        @(negedge clk);
        chk("R11 done one cycle", {done, busy}, 0);
    endtask

    task automatic check_good(input bit wr, input bit unit, input [7:0] ch, input [7:0] cl,
                              input [7:0] sc, input int seed);
        int base, mism;
        logic [4:0] es [0:5];
        logic [7:0] ed [0:5];
        base = 0;
        if (exp_nrdy) begin
            chk("R2 reset assert sel", lsel[0], 5'h16);
            chk("R2 reset assert val", ldat[0], 8'h0E);
            chk("R2 reset release sel", lsel[1], 5'h16);
            chk("R2 reset release val", ldat[1], 8'h02);
            chk("R2 reset delay", int'((ctl_t1 - ctl_t0) >= RSTC), 1);
            base = 2;
        end
        chk("R9 register write count", nlog, base + 6);
        es[0] = 5'h0A; ed[0] = 8'h01;
        es[1] = 5'h0E; ed[1] = unit ? 8'hF0 : 8'hE0;
        es[2] = 5'h0D; ed[2] = ch;
        es[3] = 5'h0C; ed[3] = cl;
        es[4] = 5'h0B; ed[4] = sc;
        es[5] = 5'h0F; ed[5] = wr ? 8'h30 : 8'h20;
        for (int j = 0; j < 5; j++) begin
            chk("R3 task file sel", lsel[base + j], es[j]);
            chk("R3 task file val", ldat[base + j], ed[j]);
        end
        chk("R4 command sel", lsel[base + 5], es[5]);
        chk("R4 command val", ldat[base + 5], ed[5]);
        mism = 0;
        if (wr) begin
            chk("R8 words written", nwr, 256);
            for (int i = 0; i < 256; i++) if (wmem[i] !== bpat(seed, i)) mism++;
        end else begin
            chk("R8 words read", nrd, 256);
            for (int i = 0; i < 256; i++) if (bmem[i] !== dpat(seed, i)) mism++;
        end
        chk("R8 data mismatches", mism, 0);
        chk("R11 result ok", rc_c, 0);
        chk("R11 status latched", st_c, 8'h50);
        chk("R11 error cleared", er_c, 0);
        exp_nrdy = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 idle after reset", {busy, done, dev_rd, dev_wr, buf_we}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after release", {busy, done, dev_rd, dev_wr, buf_we}, 0);

        // sweep both directions, both units, varied addresses
        for (int k = 0; k < 8; k++) begin
            logic [7:0] ch, cl, sc;
            ch = 8'(8'h11 * k + 3); cl = ~ch; sc = 8'(k * 7 + 1);
            run(k[0], {1'b0, k[1]}, ch, cl, sc, k + 1);
            check_good(k[0], k[1], ch, cl, sc, k + 1);
        end

        // illegal unit with flag clear
        run(1'b0, 2'd2, 8'h00, 8'h00, 8'h01, 20);
        chk("R10 bad unit result", rc_c, 4);
        chk("R10 bad unit no writes", nlog, 0);
        chk("R10 bad unit no reads", nstat, 0);
        chk("R10 bad unit latency", int'(lat_c <= 2), 1);
        run(1'b0, 2'd1, 8'h42, 8'h24, 8'h09, 21);
        check_good(1'b0, 1'b1, 8'h42, 8'h24, 8'h09, 21);

        // ready timeout
        k_bsy = 1'b1;
        run(1'b0, 2'd0, 8'h01, 8'h02, 8'h03, 22);
        k_bsy = 1'b0;
        chk("R5 ready timeout result", rc_c, 2);
        chk("R5 ready poll count", nstat, RDYL);
        chk("R5 no task file", nlog, 0);
        chk("R5 status latched", st_c, 8'h80);
        exp_nrdy = 1'b1;

        // illegal unit with flag set leaves it set
        run(1'b1, 2'd3, 8'h00, 8'h00, 8'h01, 23);
        chk("R10 bad unit result flag set", rc_c, 4);
        chk("R10 bad unit no bus flag set", nlog, 0);
        run(1'b1, 2'd0, 8'h77, 8'h88, 8'h99, 24);
        check_good(1'b1, 1'b0, 8'h77, 8'h88, 8'h99, 24);

        // error after command
        k_errcmd = 1'b1;
        run(1'b0, 2'd0, 8'h10, 8'h20, 8'h30, 25);
        k_errcmd = 1'b0;
        chk("R7 cmd error result", rc_c, 1);
        chk("R7 cmd error byte", er_c, 8'h04);
        chk("R7 cmd error status", st_c, 8'h59);
        chk("R7 error reg read once", nerr, 1);
        chk("R7 no data phase", nrd, 0);
        exp_nrdy = 1'b1;
        run(1'b0, 2'd1, 8'h31, 8'h32, 8'h33, 26);
        check_good(1'b0, 1'b1, 8'h31, 8'h32, 8'h33, 26);

        // data-request timeout
        k_nodrq = 1'b1;
        run(1'b1, 2'd1, 8'h05, 8'h06, 8'h07, 27);
        k_nodrq = 1'b0;
        chk("R6 drq timeout result", rc_c, 3);
        chk("R6 status read count", nstat, 3 + DRQL);
        chk("R6 no data words", nwr, 0);
        exp_nrdy = 1'b1;

        // error after data phase (read and write)
        k_errdata = 1'b1;
        run(1'b0, 2'd0, 8'h55, 8'h66, 8'h77, 28);
        chk("R7 data error result", rc_c, 1);
        chk("R7 data error words", nrd, 256);
        chk("R7 data error status", st_c, 8'h51);
        chk("R2 reset before data error cmd", nctl, 2);
        run(1'b1, 2'd1, 8'h56, 8'h67, 8'h78, 29);
        chk("R7 write data error result", rc_c, 1);
        chk("R9 reset after failure", nctl, 2);
        k_errdata = 1'b0;
        exp_nrdy = 1'b1;
        run(1'b1, 2'd1, 8'hA0, 8'hB0, 8'hC0, 30);
        check_good(1'b1, 1'b1, 8'hA0, 8'hB0, 8'hC0, 30);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule